// File: doc/BRIEF.md
# Addressable Shift Register with Cascade Output

The block is a single-bit delay line of 32 stages. While the shift enable is high, every rising clock edge takes a new bit from the serial input into the first stage and pushes each stored bit one stage deeper. While the enable is low, the stored bits do not change. Stored contents have no reset. They are defined only after enough enabled shifts have filled the stages.

Two outputs read the line. The tap output is a plain multiplexer steered by a 5-bit stage select. It needs no clock edge, so a new select value shows its stage in the same cycle. The cascade output is wired to the deepest stage and ignores the select. Feeding it into the serial input of a second unit that shares the clock and the enable makes a longer delay line. Two such units form 64 stages.

If the select changes in the same cycle as an enabled edge, the tap value for that cycle is undefined. Users hold the select steady across an enabled edge when they need the value.

Top module: `tap_shift_reg`

## Requirements
- R1: With shift_en low at a rising edge, every stage keeps its value whatever ser_in carries, so tap_q (at any tap_sel) and cas_q are unchanged.
- R2: With shift_en high at a rising edge, stage 0 takes ser_in and stage k takes the former value of stage k-1, for k from 1 to 31.
- R3: tap_q shows the stage whose index is the unsigned value of tap_sel. With tap_sel at 0, tap_q shows the bit taken in at the latest enabled edge.
- R4: tap_q follows a change of tap_sel between clock edges with no clock edge in between.
- R5: cas_q always equals stage 31, whatever the value of tap_sel. The first bit taken in appears on cas_q after the 32nd enabled edge.
- R6: With tap_sel = N, tap_q returns the bit taken in N enabled edges before the latest one.
- R7: When a second unit's ser_in is driven by the first unit's cas_q, and both units share the clock and shift_en, the second unit's cas_q returns the bit taken in 63 enabled edges before the latest one. The pair acts as a 64-stage line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. Shifting happens on the rising edge. |
| shift_en | input | 1 | Shift enable, active high. |
| ser_in | input | 1 | Serial data into stage 0. |
| tap_sel | input | 5 | Selects the stage shown on tap_q. |
| tap_q | output | 1 | Combinational read of the selected stage. |
| cas_q | output | 1 | Deepest stage, used to chain units. |

## Verification
The bench targets the deepest stage. If the stage index is off by one, the first bit reaches cas_q one edge early or one edge late, or shows at select 31 as a neighbour's value. Full select sweeps between edges catch a tap read that was registered by mistake, because that read would lag the select by a cycle. Hold intervals toggle ser_in with the enable low, so a design that shifts without the enable loses its stored pattern. A two-unit chain filled past 64 bits catches a cascade taken from the wrong stage, because that error shortens or lengthens the combined delay.

// File: rtl/tap_shift_reg.sv
module tap_shift_reg #(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          shift_en,
  input  logic          ser_in,
  input  logic [AW-1:0] tap_sel,
  output logic          tap_q,
  output logic          cas_q
);

  logic [DEPTH-1:0] stages;

  always_ff @(posedge clk)
    if (shift_en) stages <= {stages[DEPTH-2:0], ser_in};

  assign tap_q = stages[tap_sel];
  assign cas_q = stages[DEPTH-1];

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk)
    !shift_en |=> (stages === $past(stages))); // R1
  AST_SHIFT_IN: assert property (@(posedge clk)
    shift_en |=> (stages[0] === $past(ser_in))); // R2
  AST_SHIFT_MOVE: assert property (@(posedge clk)
    shift_en |=> (stages[DEPTH-1:1] === $past(stages[DEPTH-2:0]))); // R2
  AST_CASCADE_DEEPEST: assert property (@(posedge clk)
    shift_en |=> (cas_q === $past(stages[DEPTH-2]))); // R5

endmodule

// File: tb/tap_shift_reg_tb_top.sv
`timescale 1ns/10ps
module tap_shift_reg_tb_top;
  logic clk = 1'b0;
  logic shift_en = 1'b0;
  logic ser_in = 1'b0;
  logic [4:0] tap_sel = '0;
  logic tap_q, cas_q, tap2_q, cas2_q;
  logic [63:0] mdl = '0;
  int nshift = 0;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always #2.5 clk = ~clk;

  tap_shift_reg dut_i (.clk(clk), .shift_en(shift_en), .ser_in(ser_in),
    .tap_sel(tap_sel), .tap_q(tap_q), .cas_q(cas_q));
  tap_shift_reg chain_i (.clk(clk), .shift_en(shift_en), .ser_in(cas_q),
    .tap_sel(5'd31), .tap_q(tap2_q), .cas_q(cas2_q));

  task automatic chk(input bit ok, input string req, input logic act, input logic exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic logic next_bit();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  task automatic shift_one(input logic b);
    @(negedge clk);
    shift_en = 1'b1;
    ser_in = b;
    @(posedge clk);
    mdl = {mdl[62:0], b};
    nshift++;
    @(negedge clk);
    shift_en = 1'b0;
  endtask

  task automatic sweep(input string req);
    @(negedge clk);
    for (int a = 0; a < 32; a++) begin
      tap_sel = a[4:0];
      #0.05;
      chk(tap_q === mdl[a], req, tap_q, mdl[a]);
    end
  endtask

  task automatic t_first_bit();
    shift_one(1'b1);
    for (int i = 0; i < 30; i++) shift_one(1'b0);
    shift_one(1'b0);
    #0.1;
    chk(cas_q === 1'b1, "R5 first bit after 32 shifts", cas_q, 1'b1);
    shift_one(1'b0);
    #0.1;
    chk(cas_q === 1'b0, "R5 second bit after 33 shifts", cas_q, 1'b0);
  endtask

  task automatic t_addr0();
    tap_sel = 5'd0;
    shift_one(1'b1);
    #0.1;
    chk(tap_q === 1'b1, "R3 addr0 latest bit", tap_q, 1'b1);
    shift_one(1'b0);
    #0.1;
    chk(tap_q === 1'b0, "R3 addr0 latest bit", tap_q, 1'b0);
    shift_one(1'b1);
    #0.1;
    chk(tap_q === 1'b1, "R2 stage0 takes ser_in", tap_q, 1'b1);
  endtask

  task automatic t_pattern_sweep();
    for (int i = 0; i < 32; i++) shift_one(next_bit());
    sweep("R4 R6 comb sweep random");
    for (int i = 0; i < 32; i++) shift_one(i[0]);
    sweep("R6 alternating pattern");
    for (int i = 0; i < 32; i++) shift_one(i % 3 == 0);
    sweep("R3 sparse pattern");
  endtask

  task automatic t_hold();
    logic [31:0] saved;
    saved = mdl[31:0];
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      shift_en = 1'b0;
      ser_in = ~ser_in;
      @(posedge clk);
    end
    sweep("R1 hold with enable low");
    #0.1;
    chk(cas_q === saved[31], "R1 cascade held", cas_q, saved[31]);
  endtask

  task automatic t_cascade_sel();
    for (int a = 0; a < 32; a += 5) begin
      @(negedge clk);
      tap_sel = a[4:0];
      #0.1;
      chk(cas_q === mdl[31], "R5 cascade ignores tap_sel", cas_q, mdl[31]);
    end
    tap_sel = 5'd31;
    #0.1;
    chk(tap_q === cas_q, "R5 tap31 equals cascade", tap_q, cas_q);
  endtask

  task automatic t_chain();
    for (int i = 0; i < 70; i++) begin
      shift_one(next_bit());
      #0.1;
      chk(cas2_q === mdl[63], "R7 chained 64-stage delay", cas2_q, mdl[63]);
    end
    @(negedge clk);
    #0.1;
    chk(tap2_q === mdl[63], "R7 second unit tap31", tap2_q, mdl[63]);
  endtask

  initial begin
    t_first_bit();
    t_addr0();
    t_pattern_sweep();
    t_hold();
    t_cascade_sel();
    t_chain();
    t_hold();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%b expected=%b", 1'b0, 1'b1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule